// File: doc/BRIEF.md
# Asynchronous Register Bridge with Processor Wait States

This block lets a processor reach a register file that runs on a separate, unrelated clock. The peripheral domain runs at a fixed 16 MHz. The processor clock may run at any frequency. The processor presents an address and a read or write strobe in its own clock domain. The bridge captures the access, carries it into the peripheral domain and performs one access on a plain register-file port. It then returns a completion indication, and read data for a read, to the processor.

Only one access is in flight at a time. The wait output is the back-pressure signal, and the processor follows three rules:
- It holds the address, the write data and its strobe steady for as long as wait is high.
- The access completes at the first rising processor edge at which wait is low with a strobe present. Read data is valid at that edge.
- It drops or changes the strobe after that edge. A strobe still present afterwards starts a new access.

The request and the acknowledge each cross the boundary as a toggle through a synchronizer chain. The number of wait cycles therefore follows the clock ratio. A fast processor waits many of its own cycles. A processor whose period is at least four peripheral periods waits only for the fixed synchronizer floor.

Top module: `regbridge_async`

## Requirements
- R1: After reset, cpu_wait is low when no strobe is present, reg_we is low, and cpu_rdata reads 0.
- R2: A processor write produces exactly one reg_we pulse on the peripheral port. The pulse carries the processor's address and write data unchanged, and both stay stable for the whole pulse.
- R3: A processor read returns on cpu_rdata the content of the addressed register at the completing edge. A read never asserts reg_we.
- R4: The write commits on the peripheral port no later than the third rising peripheral clock edge after the processor edge that accepts the access.
- R5: cpu_wait is high from the first cycle a strobe is presented until the access completes. cpu_wait is low whenever no strobe is present.
- R6: cpu_rdata holds the last read value from completion until the next read is accepted, including through idle cycles.
- R7: With the default two-stage synchronizers, each access shows at least 3 processor wait cycles and at most ceil(3*Tper/Tcpu)+3. When the processor period is at least four peripheral periods, each access shows exactly 3 wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst_n | input | 1 | Processor-domain reset, active low |
| cpu_addr | input | AW | Register address |
| cpu_wdata | input | DW | Write data |
| cpu_rd | input | 1 | Read strobe, held until wait is low |
| cpu_wr | input | 1 | Write strobe, held until wait is low |
| cpu_wait | output | 1 | Stall request to the processor |
| cpu_rdata | output | DW | Read data, valid when the access completes |
| per_clk | input | 1 | Peripheral clock, 16 MHz |
| per_rst_n | input | 1 | Peripheral-domain reset, active low |
| reg_addr | output | AW | Register-file address |
| reg_we | output | 1 | Register-file write enable, one cycle per write |
| reg_wdata | output | DW | Register-file write data |
| reg_rdata | input | DW | Register-file read data, combinational from reg_addr |

## Verification
The bench runs the same access mix at three processor clock rates: far faster than the peripheral clock, near it, and four times slower. For each rate it checks that the stall count lies in the derived window. A bridge that released wait before the acknowledge arrived would show too few stalls and return stale read data. One that missed a toggle edge would hang until the watchdog. Addresses 0 and the top address catch truncated buses, and a write pulse that lasts two cycles or appears during a read is counted as an unexpected write. After each read the bench idles for several cycles and then rechecks cpu_rdata, which catches a holding register that is cleared or tracks reg_rdata.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;
  typedef enum logic {
    BRG_IDLE = 1'b0,
    BRG_BUSY = 1'b1
  } brg_state_e;
endpackage

// File: rtl/rb_tgl_sync.sv
module rb_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rb_cpu_side.sv
module rb_cpu_side
  import regbridge_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic          cpu_wait,
  input  logic          ack_sync,
  output logic          req_tgl,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          we_q
);
  brg_state_e state;
  logic       ack_last;
  logic       strobe;
  logic       ack_edge;

  assign strobe   = cpu_rd | cpu_wr;
  assign ack_edge = ack_sync ^ ack_last;
  assign cpu_wait = strobe & ~((state == BRG_BUSY) & ack_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= BRG_IDLE;
      req_tgl  <= 1'b0;
      ack_last <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
    end else begin
      case (state)
        BRG_IDLE: if (strobe) begin
          addr_q  <= cpu_addr;
          wdata_q <= cpu_wdata;
          we_q    <= cpu_wr;
          req_tgl <= ~req_tgl;
          state   <= BRG_BUSY;
        end
        BRG_BUSY: if (ack_edge) begin
          ack_last <= ack_sync;
          state    <= BRG_IDLE;
        end
        default: state <= BRG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rb_per_side.sv
module rb_per_side #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_sync,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic          we_q,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          ack_tgl,
  output logic [DW-1:0] rd_hold
);
  logic req_last;
  logic go;

  // The captured request fields are quasi-static: they are only changed
  // by the processor side while no access is in flight.
  assign go        = req_sync ^ req_last;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = go & we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_last <= 1'b0;
      ack_tgl  <= 1'b0;
      rd_hold  <= '0;
    end else if (go) begin
      req_last <= req_sync;
      ack_tgl  <= ~ack_tgl;
      if (!we_q) rd_hold <= reg_rdata;
    end
  end
endmodule

// File: rtl/regbridge_async.sv
module regbridge_async #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          cpu_clk,
  input  logic          cpu_rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic          cpu_wait,
  output logic [DW-1:0] cpu_rdata,
  input  logic          per_clk,
  input  logic          per_rst_n,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  logic          req_tgl, req_sync;
  logic          ack_tgl, ack_sync;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q;
  logic [DW-1:0] rd_hold;

  rb_cpu_side #(.AW(AW), .DW(DW)) u_cpu (
    .clk(cpu_clk), .rst_n(cpu_rst_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wait(cpu_wait),
    .ack_sync(ack_sync), .req_tgl(req_tgl),
    .addr_q(addr_q), .wdata_q(wdata_q), .we_q(we_q)
  );

  rb_tgl_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(per_clk), .rst_n(per_rst_n), .d(req_tgl), .q(req_sync)
  );

  rb_per_side #(.AW(AW), .DW(DW)) u_per (
    .clk(per_clk), .rst_n(per_rst_n), .req_sync(req_sync),
    .addr_q(addr_q), .wdata_q(wdata_q), .we_q(we_q),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_tgl(ack_tgl), .rd_hold(rd_hold)
  );

  rb_tgl_sync #(.STAGES(SYNC_STG)) u_ack_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_sync)
  );

  assign cpu_rdata = rd_hold;
endmodule

// File: rtl/regbridge_async_chk.sv
module regbridge_async_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          cpu_clk,
  input logic          cpu_rst_n,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic          cpu_wait,
  input logic [DW-1:0] cpu_rdata,
  input logic          per_clk,
  input logic          per_rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata
);
  // R5
  idle_no_wait_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !(cpu_rd || cpu_wr) |-> !cpu_wait);

  // R2
  single_we_chk: assert property (@(posedge per_clk) disable iff (!per_rst_n)
    reg_we |=> !reg_we);

  // R2
  we_fields_stable_chk: assert property (@(posedge per_clk) disable iff (!per_rst_n)
    reg_we |-> ($stable(reg_addr) && $stable(reg_wdata)));

  // R6
  rdata_settled_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (cpu_rd && !cpu_wait) |-> $stable(cpu_rdata));

  // R3
  no_we_on_read_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (cpu_rd && !cpu_wr) |-> !reg_we || cpu_wait);
endmodule

bind regbridge_async regbridge_async_chk #(.AW(AW), .DW(DW)) u_chk (
  .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata), .per_clk(per_clk),
  .per_rst_n(per_rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata)
);

// File: tb/regbridge_async_bench.sv
`timescale 1ps/1ps
module regbridge_async_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NREG = 1 << AW;

  int   cpu_half = 2000;
  logic cpu_clk = 1'b0;
  logic per_clk = 1'b0;
  logic cpu_rst_n = 1'b0, per_rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic cpu_wait;
  logic [DW-1:0] cpu_rdata;
  logic [AW-1:0] reg_addr;
  logic          reg_we;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;

  initial begin #1000; forever #(cpu_half) cpu_clk = ~cpu_clk; end
  initial forever #31250 per_clk = ~per_clk;

  regbridge_async #(.AW(AW), .DW(DW)) u_regbridge_async (.*);

  // peripheral register file model
  logic [DW-1:0] mem [NREG];
  always_ff @(posedge per_clk) begin
    if (!per_rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= DW'(i * 7 + 3);
    end else if (reg_we) mem[reg_addr] <= reg_wdata;
  end
  assign reg_rdata = mem[reg_addr];

  logic [DW-1:0] shadow [NREG];
  int errs = 0, checks = 0;
  logic [DW-1:0]      rq[$];
  logic [AW+DW-1:0]   wq[$];
  int per_edges = 0, acc_mark = 0;
  bit acc_pend = 0;
  logic [DW-1:0] last_rd = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge per_clk) per_edges++;
  always @(posedge cpu_clk) if (acc_pend) begin acc_mark = per_edges; acc_pend = 0; end

  // read monitor (scoreboard pop)
  always @(negedge cpu_clk) begin
    if (cpu_rst_n && cpu_rd && !cpu_wait) begin
      if (rq.size() == 0) chk(0, "R3 unexpected read completion", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = rq.pop_front();
        chk(cpu_rdata == e, "R3 read data", int'(cpu_rdata), int'(e));
        last_rd = e;
      end
    end
  end

  // write monitor (scoreboard pop)
  always @(negedge per_clk) begin
    if (per_rst_n && reg_we) begin
      if (wq.size() == 0) chk(0, "R3 R2 unexpected reg_we", 1, 0);
      else begin
        logic [AW+DW-1:0] e;
        e = wq.pop_front();
        chk({reg_addr, reg_wdata} == e, "R2 write fields",
            int'({reg_addr, reg_wdata}), int'(e));
        chk((per_edges - acc_mark) >= 1 && (per_edges - acc_mark) <= 2,
            "R4 commit within three peripheral edges", per_edges - acc_mark, 2);
      end
    end
  end

  task automatic access(input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output int stalls);
    @(posedge cpu_clk); #100;
    cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = !wr; acc_pend = 1;
    if (wr) begin wq.push_back({a, d}); shadow[a] = d; end
    else rq.push_back(shadow[a]);
    stalls = 0;
    forever begin
      @(negedge cpu_clk);
      if (cpu_wait) stalls++; else break;
      if (stalls > 5000) break;
    end
    @(posedge cpu_clk); #100;
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic run_ratio(input int half, input int lo, input int hi, input string tag);
    int st;
    logic [AW-1:0] addrs [4];
    cpu_half = half;
    repeat (4) @(posedge cpu_clk);
    addrs[0] = 8'h00; addrs[1] = 8'hFF; addrs[2] = 8'h5A; addrs[3] = 8'h81;
    for (int i = 0; i < 3; i++) begin
      access(1'b1, addrs[i], DW'(8'hC3 ^ (i * 37) ^ half), st);
      chk(st >= lo && st <= hi, {"R7 R5 write stall ", tag}, st, lo);
    end
    for (int i = 0; i < 4; i++) begin
      access(1'b0, addrs[i], '0, st);
      chk(st >= lo && st <= hi, {"R7 R5 read stall ", tag}, st, lo);
    end
    repeat (5) @(negedge cpu_clk);
    chk(cpu_rdata == last_rd, {"R6 rdata held idle ", tag}, int'(cpu_rdata), int'(last_rd));
    chk(cpu_wait == 1'b0, {"R5 no wait while idle ", tag}, int'(cpu_wait), 0);
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < NREG; i++) shadow[i] = DW'(i * 7 + 3);
    repeat (3) @(posedge per_clk);
    @(negedge cpu_clk);
    chk(cpu_wait == 1'b0, "R1 wait after reset", int'(cpu_wait), 0);
    chk(cpu_rdata == '0, "R1 rdata after reset", int'(cpu_rdata), 0);
    chk(reg_we == 1'b0, "R1 reg_we after reset", int'(reg_we), 0);
    cpu_rst_n = 1'b1; per_rst_n = 1'b1;
    repeat (3) @(posedge per_clk);
    run_ratio(2000, 3, 50, "fast");
    run_ratio(20000, 3, 8, "mid");
    run_ratio(125000, 3, 3, "slow");
    chk(rq.size() == 0 && wq.size() == 0, "R2 R3 scoreboard drained",
        int'(rq.size() + wq.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #500_000_000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule